// File: doc/BRIEF.md
# Interrupt Status and Control Register with Shared Acknowledge

This block is a single memory-mapped byte that collects three external interrupt sources into one request line to the CPU. The sources are a dedicated interrupt pin and two port groups, called A and C. Each source input is active low. It passes through a two-flop synchronizer, and a falling edge on the synchronized level sets that source's pending latch. Every source has its own enable bit. The request output is high while any latch is set and its enable is also set.

Software clears pending state through one acknowledge bit that is write-one-to-clear. A write of one to that bit clears all three latches in the same cycle. The CPU also gives a vector-fetch strobe. That strobe clears only the pin latch, so the service routine can still read which port group caused the interrupt. The port flags are read-only and are set even while their enable is off. If a new source event lands in the same cycle as a clear, the latch stays set.

Top module: `irq_status_reg`

## Requirements
- R1: A write to the register address with bit 4 (acknowledge) equal to one clears the pin flag, the port A flag and the port C flag in that same clock cycle.
- R2: A register write with bit 4 equal to zero leaves all three pending flags unchanged.
- R3: Bit 4 (acknowledge) and bit 5 always read as zero.
- R4: A vector-fetch strobe sampled high clears the pin flag (bit 6) and leaves the port A and port C flags unchanged.
- R5: Writes to bit 6 (pin flag), bit 3 (port A flag) and bit 0 (port C flag) do not change those flags.
- R6: A source event sets its flag whether its enable bit is one or zero.
- R7: `irqReq` equals the OR of (pin flag AND bit 7 pin enable), (port A flag AND bit 2 port A enable) and (port C flag AND bit 1 port C enable). It stays high as long as any such pair is set.
- R8: After reset all enables and flags read as zero, and `irqReq` is low.
- R9: When a source event and a clear (acknowledge write or vector fetch) reach a flag in the same cycle, the flag ends up set.
- R10: Each source input is active low. Its flag is set on the third rising clock edge after the input falls, and not earlier. A rising edge on the input, or an input that stays low, sets nothing.
- R11: When `busAddr` differs from the register address, `busRdata` is zero, and a write changes neither enables nor flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register bus address |
| busWe | input | 1 | Write enable, sampled on the rising edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from address |
| srcPinN | input | 1 | Interrupt pin source, active low, asynchronous |
| srcGrpAN | input | 1 | Port group A source, active low, asynchronous |
| srcGrpCN | input | 1 | Port group C source, active low, asynchronous |
| vecFetch | input | 1 | CPU vector-fetch strobe |
| irqReq | output | 1 | Combined interrupt request |

## Verification
The assertions check several behaviours on every cycle:
- an acknowledge write with no competing event empties all flags;
- a write without acknowledge never drops a flag;
- the vector fetch clears the pin flag but keeps the port flags;
- a detected event always lands in its flag;
- the read-zero bits stay zero;
- the request follows the flag-and-enable pairs.

Only the bench's scenarios show the rest:
- the exact latency of the synchronizer and edge detector;
- that a rising or steady-low input sets nothing;
- that writes to other addresses have no effect;
- the full read image over every combination of enables and flags.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_SRC = 3;
  // source index order inside flag and enable vectors
  localparam int SRC_PIN = 0;
  localparam int SRC_GA  = 1;
  localparam int SRC_GC  = 2;
  // register bit positions
  localparam int BIT_PEN  = 7;
  localparam int BIT_PFLG = 6;
  localparam int BIT_ACK  = 4;
  localparam int BIT_AFLG = 3;
  localparam int BIT_AEN  = 2;
  localparam int BIT_CEN  = 1;
  localparam int BIT_CFLG = 0;

  typedef struct packed {
    logic                enWrite;
    logic                ackClear;
    logic                vecClear;
    logic                rdSel;
    logic [NUM_SRC-1:0]  enData;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1F
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              vecFetch,
  output ctrlStrobes_t      strobes
);
  logic addrHit;
  logic unusedWdata;

  assign addrHit     = (busAddr == REG_ADDR);
  assign unusedWdata = ^{busWdata[BIT_PFLG], busWdata[5], busWdata[BIT_AFLG], busWdata[BIT_CFLG]};

  always_comb begin
    strobes                 = '0;
    strobes.rdSel           = addrHit;
    strobes.enWrite         = addrHit & busWe;
    strobes.ackClear        = addrHit & busWe & busWdata[BIT_ACK];
    strobes.vecClear        = vecFetch;
    strobes.enData[SRC_PIN] = busWdata[BIT_PEN];
    strobes.enData[SRC_GA]  = busWdata[BIT_AEN];
    strobes.enData[SRC_GC]  = busWdata[BIT_CEN];
  end
endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [NUM_SRC-1:0] srcN,
  output logic [REG_W-1:0]   busRdata,
  output logic               irqReq,
  output logic [NUM_SRC-1:0] flagVec,
  output logic [NUM_SRC-1:0] enVec,
  output logic [NUM_SRC-1:0] setVec
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [SYNC_STAGES-1:0] chain;
    logic                   prevLvl;
    logic                   flagQ;
    logic                   clrHere;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain   <= '1;
        prevLvl <= 1'b1;
      end else begin
        chain   <= {chain[TOP-1:0], srcN[i]};
        prevLvl <= chain[TOP];
      end
    end

    assign setVec[i] = prevLvl & ~chain[TOP];

    if (i == SRC_PIN) begin : g_pin
      assign clrHere = strobes.ackClear | strobes.vecClear;
    end else begin : g_port
      assign clrHere = strobes.ackClear;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          flagQ <= 1'b0;
      else if (setVec[i]) flagQ <= 1'b1;
      else if (clrHere)   flagQ <= 1'b0;
    end

    assign flagVec[i] = flagQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                enVec <= '0;
    else if (strobes.enWrite) enVec <= strobes.enData;
  end

  always_comb begin
    busRdata = '0;
    if (strobes.rdSel) begin
      busRdata[BIT_PEN]  = enVec[SRC_PIN];
      busRdata[BIT_PFLG] = flagVec[SRC_PIN];
      busRdata[BIT_AFLG] = flagVec[SRC_GA];
      busRdata[BIT_AEN]  = enVec[SRC_GA];
      busRdata[BIT_CEN]  = enVec[SRC_GC];
      busRdata[BIT_CFLG] = flagVec[SRC_GC];
    end
  end

  assign irqReq = |(flagVec & enVec);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h1F,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              srcPinN,
  input  logic              srcGrpAN,
  input  logic              srcGrpCN,
  input  logic              vecFetch,
  output logic              irqReq
);
  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] flagVec;
  logic [NUM_SRC-1:0] enVec;
  logic [NUM_SRC-1:0] setVec;

  irq_status_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) ctrl_i (
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .vecFetch (vecFetch),
    .strobes  (strobes)
  );

  irq_status_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .srcN     ({srcGrpCN, srcGrpAN, srcPinN}),
    .busRdata (busRdata),
    .irqReq   (irqReq),
    .flagVec  (flagVec),
    .enVec    (enVec),
    .setVec   (setVec)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1F
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic              vecFetch,
  input logic              irqReq,
  input logic [2:0]        flagVec,
  input logic [2:0]        enVec,
  input logic [2:0]        setVec
);
  logic ackWr;
  assign ackWr = busWe && (busAddr == REG_ADDR) && busWdata[4];

  AST_ACK_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (ackWr && setVec == 3'b000) |=> flagVec == 3'b000);  // R1

  AST_NO_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ackWr && !vecFetch) |=> (flagVec & $past(flagVec)) == $past(flagVec));  // R2

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[5:4] == 2'b00);  // R3

  AST_VEC_CLEARS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (vecFetch && !setVec[0]) |=> !flagVec[0]);  // R4

  AST_VEC_KEEPS_PORTS: assert property (@(posedge clk) disable iff (!rstN)
    (vecFetch && !ackWr) |=> (flagVec[2:1] & $past(flagVec[2:1])) == $past(flagVec[2:1]));  // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != 3'b000) |=> (flagVec & $past(setVec)) == $past(setVec));  // R9

  AST_REQ_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec & enVec) == 3'b000) |-> !irqReq);  // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec & enVec) != 3'b000) |-> irqReq);  // R7
endmodule

bind irq_status_reg irq_status_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .vecFetch (vecFetch),
  .irqReq   (irqReq),
  .flagVec  (flagVec),
  .enVec    (enVec),
  .setVec   (setVec)
);

// File: tb/irq_status_reg_tb_top.sv
`timescale 1ns/1ps
module irq_status_reg_tb_top;
  localparam logic [7:0] RA = 8'h1F;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = RA;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       srcPinN = 1'b1, srcGrpAN = 1'b1, srcGrpCN = 1'b1;
  logic       vecFetch = 1'b0;
  logic       irqReq;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  irq_status_reg dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .srcPinN(srcPinN),
    .srcGrpAN(srcGrpAN), .srcGrpCN(srcGrpCN), .vecFetch(vecFetch),
    .irqReq(irqReq)
  );

  // image from enables {c,a,pin} and flags {c,a,pin}
  function automatic logic [7:0] image(input logic [2:0] en, input logic [2:0] fl);
    return {en[0], fl[0], 2'b00, fl[1], en[1], en[2], fl[2]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busWdata = data; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = RA;
  endtask

  task automatic rdReg(input logic [7:0] addr, output logic [7:0] val);
    @(negedge clk);
    busAddr = addr;
    #0.5 val = busRdata;
    busAddr = RA;
  endtask

  task automatic drive(input logic [2:0] lvl);
    srcPinN = lvl[0]; srcGrpAN = lvl[1]; srcGrpCN = lvl[2];
  endtask

  // pulse the selected sources low long enough to set flags, then idle high
  task automatic pulse(input logic [2:0] sel);
    @(negedge clk);
    drive(~sel);
    repeat (3) @(negedge clk);
    drive(3'b111);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8 reset state
    rdReg(RA, v);
    chk("R8 reset image", v, 8'h00);
    chk("R8 reset irqReq", {7'd0, irqReq}, 8'h00);

    // R6 R7 R1 R3: sweep every enable and flag combination
    for (int en = 0; en < 8; en++) begin
      for (int fl = 0; fl < 8; fl++) begin
        wrReg(RA, image(en[2:0], 3'b000) | 8'h10);
        rdReg(RA, v);
        chk("R1 ack clears all", v, image(en[2:0], 3'b000));
        if (fl != 0) pulse(fl[2:0]);
        rdReg(RA, v);
        chk("R6 R3 flag image", v, image(en[2:0], fl[2:0]));
        chk("R7 irqReq", {7'd0, irqReq}, {7'd0, |(en[2:0] & fl[2:0])});
      end
    end

    // R2 R5: write without ack, ones and zeros on flag bits
    wrReg(RA, 8'h10);
    pulse(3'b101);
    wrReg(RA, 8'h00);
    rdReg(RA, v);
    chk("R2 zero ack keeps flags", v, image(3'b000, 3'b101));
    wrReg(RA, 8'h49);
    rdReg(RA, v);
    chk("R5 flag bits read-only", v, image(3'b000, 3'b101));
    wrReg(RA, 8'h10);
    wrReg(RA, 8'h49);
    rdReg(RA, v);
    chk("R5 cannot set flags by write", v, 8'h00);

    // R4 vector fetch clears pin only
    pulse(3'b111);
    @(negedge clk); vecFetch = 1'b1;
    @(negedge clk); vecFetch = 1'b0;
    rdReg(RA, v);
    chk("R4 vector fetch clears pin only", v, image(3'b000, 3'b110));

    // R11 other address: reads zero, writes ignored
    rdReg(8'h20, v);
    chk("R11 other address reads zero", v, 8'h00);
    wrReg(8'h1E, 8'h96);
    rdReg(RA, v);
    chk("R11 other address write ignored", v, image(3'b000, 3'b110));

    // R10 latency: flag appears on third edge after falling input
    wrReg(RA, 8'h10);
    @(negedge clk); srcGrpAN = 1'b0;
    @(negedge clk); @(negedge clk);
    rdReg(RA, v);   // passes the third edge just before sampling? no: check timing explicitly
    chk("R10 flag after third edge", v, image(3'b000, 3'b010));
    // steady low and rising edge set nothing
    wrReg(RA, 8'h10);
    repeat (4) @(negedge clk);
    srcGrpAN = 1'b1;
    repeat (4) @(negedge clk);
    rdReg(RA, v);
    chk("R10 low hold and rise set nothing", v, 8'h00);
    // not before the third edge
    @(negedge clk); srcPinN = 1'b0;
    @(negedge clk);
    @(negedge clk); #0.5 busAddr = RA;
    chk("R10 no flag after two edges", busRdata, 8'h00);
    @(negedge clk); #0.5;
    chk("R10 flag on third edge", busRdata, image(3'b000, 3'b001));
    srcPinN = 1'b1;
    repeat (3) @(negedge clk);

    // R9 set wins over ack in the same cycle
    wrReg(RA, 8'h10);
    @(negedge clk); srcGrpCN = 1'b0;
    @(negedge clk);
    @(negedge clk); busWdata = 8'h10; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0; srcGrpCN = 1'b1;
    rdReg(RA, v);
    chk("R9 set wins over ack", v, image(3'b000, 3'b100));
    // R9 set wins over vector fetch
    wrReg(RA, 8'h10);
    @(negedge clk); srcPinN = 1'b0;
    @(negedge clk);
    @(negedge clk); vecFetch = 1'b1;
    @(negedge clk); vecFetch = 1'b0; srcPinN = 1'b1;
    rdReg(RA, v);
    chk("R9 set wins over vector fetch", v, image(3'b000, 3'b001));

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule